// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical frame number by reading a radix page table held in memory, one level at a time. A translation miss is handed to it as a single request. The walker starts from the root table frame supplied on its root input. At each level it reads one 8-byte entry, then uses that entry's frame number together with the next 9-bit slice of the virtual address to locate the entry one level down.

A walk ends in one of three ways. A valid entry at the last level gives a 4 KiB mapping. A valid entry at the third level with its page-size bit set gives a 2 MiB mapping. An entry with its valid bit clear at any level gives a fault. The result appears on the response outputs, qualified by a one-cycle strobe. Only one walk runs at a time, and only one memory read is outstanding at any moment.

Top module: `pgwalk_top`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A request is taken on a clock edge where both `reqValid` and `reqReady` are high. `reqValid` and `reqVa` have no effect while a walk is in progress.
- R2: The first read is issued in the cycle after a request is taken. Its address is `{rootFrame, va[47:39], 3'b000}`.
- R3: Every later read goes to `{pte[47:12], index, 3'b000}`, where `pte` is the entry just returned. The indices are used in this order: va[47:39], va[38:30], va[29:21], va[20:12].
- R4: `memReqValid` is a one-cycle strobe, and it is low while the walker is idle. No further read is issued until `memRspValid` has returned the data for the previous read.
- R5: Entries are decoded as follows: bit 0 is the valid bit, bit 7 is the page-size bit, and bits 47:12 are the frame number. All other bits are ignored.
- R6: A valid entry at the fourth level ends the walk after 4 reads, with `respPfn = pte[47:12]`, `respHuge = 0` and `respFault = 0`. Bit 7 is ignored at this level.
- R7: A valid entry with bit 7 set at the third level ends the walk after 3 reads, with `respHuge = 1` and `respPfn = {pte[47:21], va[20:12]}`.
- R8: At the first and second levels, bit 7 is ignored: a valid entry there is always followed as a pointer to the next table.
- R9: An invalid entry at level L (0 is the root) ends the walk after L+1 reads, with `respFault = 1`, `respLevel = L`, `respHuge = 0` and `respPfn = 0`.
- R10: `respValid` is high for exactly one cycle, the cycle after the final memory response. `reqReady` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle; request can be taken |
| reqVa | input | 48 | Virtual address to translate |
| rootFrame | input | 36 | Frame number of the root table |
| memReqValid | output | 1 | Entry read strobe |
| memReqAddr | output | 48 | Byte address of the entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Page-table entry |
| respValid | output | 1 | Result strobe |
| respFault | output | 1 | Walk ended on an invalid entry |
| respHuge | output | 1 | Result is a 2 MiB mapping |
| respPfn | output | 36 | Physical frame number |
| respLevel | output | 2 | Level of the final entry read |

## Verification
The assertions assume that the memory returns exactly one `memRspValid` pulse for each `memReqValid`, never earlier than the cycle after the read, and never without a read outstanding. The read-count checks rely on this pairing. The bench's memory model is a single sequential loop that answers each observed read once, after a latency of one or more cycles. It therefore cannot raise a response with no read pending, or answer a read twice. Entries at addresses that were not written into the model read back as zero, and the fault scenarios are built on that.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_HUGE_BIT  = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walkState_e;

  typedef struct packed {
    logic capture;
    logic advance;
    logic finishLeaf;
    logic finishHuge;
    logic finishFault;
  } walkStrobe_t;

  typedef struct packed {
    logic valid;
    logic huge;
  } pteFlags_t;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int HUGE_LEVEL = 2,
  parameter int LVL_W      = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             memRspValid,
  input  pteFlags_t        flags,
  output logic             reqReady,
  output logic             memReqValid,
  output logic             respValid,
  output walkStrobe_t      strobe,
  output logic [LVL_W-1:0] level
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);
  localparam logic [LVL_W-1:0] HUGE_LVL = LVL_W'(HUGE_LEVEL);

  walkState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (!flags.valid) begin
            strobe.finishFault = 1'b1;
            stateNext          = ST_DONE;
          end else if (level == HUGE_LVL && flags.huge) begin
            strobe.finishHuge = 1'b1;
            stateNext         = ST_DONE;
          end else if (level == LAST_LVL) begin
            strobe.finishLeaf = 1'b1;
            stateNext         = ST_DONE;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_ISSUE;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      level <= '0;
    end else begin
      state <= stateNext;
      if (strobe.capture)      level <= '0;
      else if (strobe.advance) level <= level + 1'b1;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign respValid   = (state == ST_DONE);

endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int PTE_W      = 64,
  parameter int PG_SHIFT   = 12,
  parameter int IDX_W      = 9,
  parameter int LEVELS     = 4,
  parameter int HUGE_LEVEL = 2,
  parameter int LVL_W      = $clog2(LEVELS),
  parameter int FRAME_W    = PA_W - PG_SHIFT,
  parameter int VPN_W      = VA_W - PG_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [LVL_W-1:0]   level,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [FRAME_W-1:0] rootFrame,
  input  logic [PTE_W-1:0]   memRspData,
  output pteFlags_t          flags,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               respFault,
  output logic               respHuge,
  output logic [FRAME_W-1:0] respPfn,
  output logic [LVL_W-1:0]   respLevel
);

  localparam int ENTRY_SHIFT = PG_SHIFT - IDX_W;
  localparam int HUGE_LO     = (LEVELS - 1 - HUGE_LEVEL) * IDX_W;

  logic [VPN_W-1:0]   vpn;
  logic [FRAME_W-1:0] baseFrame;
  logic [FRAME_W-1:0] pteFrame;
  logic [IDX_W-1:0]   idxTab [LEVELS];

  // Index slices, root level taking the most significant slice.
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxTab[g] = vpn[(LEVELS - 1 - g) * IDX_W +: IDX_W];
  end

  assign pteFrame    = memRspData[PA_W-1:PG_SHIFT];
  assign flags.valid = memRspData[PTE_VALID_BIT];
  assign flags.huge  = memRspData[PTE_HUGE_BIT];
  assign memReqAddr  = {baseFrame, idxTab[level], {ENTRY_SHIFT{1'b0}}};

  logic unusedBits;
  assign unusedBits = ^{memRspData[PTE_W-1:PA_W], memRspData[PG_SHIFT-1:PTE_HUGE_BIT+1],
                        memRspData[PTE_HUGE_BIT-1:PTE_VALID_BIT+1], reqVa[PG_SHIFT-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpn       <= '0;
      baseFrame <= '0;
      respFault <= 1'b0;
      respHuge  <= 1'b0;
      respPfn   <= '0;
      respLevel <= '0;
    end else begin
      if (strobe.capture) begin
        vpn       <= reqVa[VA_W-1:PG_SHIFT];
        baseFrame <= rootFrame;
      end
      if (strobe.advance) baseFrame <= pteFrame;
      if (strobe.finishLeaf) begin
        respFault <= 1'b0;
        respHuge  <= 1'b0;
        respPfn   <= pteFrame;
        respLevel <= level;
      end
      if (strobe.finishHuge) begin
        respFault <= 1'b0;
        respHuge  <= 1'b1;
        respPfn   <= {pteFrame[FRAME_W-1:HUGE_LO], vpn[HUGE_LO-1:0]};
        respLevel <= level;
      end
      if (strobe.finishFault) begin
        respFault <= 1'b1;
        respHuge  <= 1'b0;
        respPfn   <= '0;
        respLevel <= level;
      end
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int PTE_W      = 64,
  parameter int PG_SHIFT   = 12,
  parameter int IDX_W      = 9,
  parameter int LEVELS     = 4,
  parameter int HUGE_LEVEL = 2,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int FRAME_W   = PA_W - PG_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [FRAME_W-1:0] rootFrame,
  output logic               memReqValid,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [PTE_W-1:0]   memRspData,
  output logic               respValid,
  output logic               respFault,
  output logic               respHuge,
  output logic [FRAME_W-1:0] respPfn,
  output logic [LVL_W-1:0]   respLevel
);

  walkStrobe_t      strobe;
  pteFlags_t        flags;
  logic [LVL_W-1:0] level;

  pgwalk_ctrl #(
    .LEVELS(LEVELS), .HUGE_LEVEL(HUGE_LEVEL), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .flags(flags), .reqReady(reqReady), .memReqValid(memReqValid),
    .respValid(respValid), .strobe(strobe), .level(level)
  );

  pgwalk_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .HUGE_LEVEL(HUGE_LEVEL), .LVL_W(LVL_W), .FRAME_W(FRAME_W),
    .VPN_W(VA_W - PG_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .level(level), .reqVa(reqVa),
    .rootFrame(rootFrame), .memRspData(memRspData), .flags(flags),
    .memReqAddr(memReqAddr), .respFault(respFault), .respHuge(respHuge),
    .respPfn(respPfn), .respLevel(respLevel)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int PA_W       = 48,
  parameter int LEVELS     = 4,
  parameter int HUGE_LEVEL = 2,
  parameter int LVL_W      = $clog2(LEVELS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             memReqValid,
  input logic [PA_W-1:0]  memReqAddr,
  input logic             respValid,
  input logic             respFault,
  input logic             respHuge,
  input logic [LVL_W-1:0] respLevel
);

  logic [LVL_W:0] readCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      readCnt <= '0;
    else if (reqValid && reqReady)  readCnt <= '0;
    else if (memReqValid)           readCnt <= readCnt + 1'b1;
  end

  // R4: one read strobe, then silence until the response
  p_single_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R4: no read while idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);

  // R1: taking a request leaves the walker busy
  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: one-cycle result strobe, then idle
  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));

  // R2: entry addresses are 8-byte aligned
  p_entry_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[2:0] == 3'b000));

  // R6: a small-page result follows a read at every level
  p_leaf_reads_r6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault && !respHuge) |-> (readCnt == (LVL_W+1)'(LEVELS)));

  // R7: a huge result ends at the third level
  p_huge_reads_r7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHuge) |-> (readCnt == (LVL_W+1)'(HUGE_LEVEL + 1)));

  // R9: a fault stops reading at the faulting level
  p_fault_reads_r9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (!respHuge && readCnt == (LVL_W+1)'(respLevel) + 1'b1));

endmodule

bind pgwalk_top pgwalk_chk #(
  .PA_W(PA_W), .LEVELS(LEVELS), .HUGE_LEVEL(HUGE_LEVEL)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr), .respValid(respValid),
  .respFault(respFault), .respHuge(respHuge), .respLevel(respLevel)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVa = '0;
  logic [35:0] rootFrame = 36'h000000100;
  logic        memReqValid;
  logic [47:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        respValid, respFault, respHuge;
  logic [35:0] respPfn;
  logic [1:0]  respLevel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
    .rootFrame(rootFrame), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .respValid(respValid),
    .respFault(respFault), .respHuge(respHuge), .respPfn(respPfn), .respLevel(respLevel)
  );

  // memory model table
  logic [47:0] tAddr [8];
  logic [63:0] tData [8];
  int          tN;

  // walk observations
  logic [47:0] rdAddr [8];
  int          rdCount;
  logic [35:0] gotPfn;
  logic        gotHuge, gotFault;
  logic [1:0]  gotLevel;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] idxOf(input logic [47:0] va, input int lvl);
    return va[12 + (3 - lvl) * 9 +: 9];
  endfunction

  function automatic logic [47:0] entryAddr(input logic [35:0] frame, input logic [47:0] va,
                                            input int lvl);
    return {frame, idxOf(va, lvl), 3'b000};
  endfunction

  // R5 format: bit0 valid, bit7 page size, 47:12 frame
  function automatic logic [63:0] mkPte(input logic [35:0] frame, input bit huge);
    return {16'h0, frame, 4'h0, huge, 6'h0, 1'b1};
  endfunction

  function automatic logic [63:0] lookup(input logic [47:0] a);
    for (int i = 0; i < tN; i++) if (tAddr[i] == a) return tData[i];
    return 64'h0;
  endfunction

  task automatic addPte(input logic [47:0] a, input logic [63:0] d);
    tAddr[tN] = a;
    tData[tN] = d;
    tN++;
  endtask

  task automatic runWalk(input logic [47:0] va, input int lat, input bit holdReq);
    bit done = 0;
    int guard = 0;
    @(negedge clk);
    reqVa = va;
    reqValid = 1'b1;
    rdCount = 0;
    @(negedge clk);
    if (holdReq) reqVa = ~va;
    else reqValid = 1'b0;
    while (!done && guard < 100) begin
      guard++;
      if (respValid) begin
        gotPfn = respPfn; gotHuge = respHuge; gotFault = respFault; gotLevel = respLevel;
        reqValid = 1'b0;
        done = 1;
        @(negedge clk);
        chk(!respValid && reqReady, "R10", "strobe width / ready after result",
            {62'h0, respValid, reqReady}, 64'h1);
      end else if (memReqValid) begin
        if (rdCount < 8) rdAddr[rdCount] = memReqAddr;
        rdCount++;
        memRspData = lookup(memReqAddr);
        repeat (lat) @(negedge clk);
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData  = '0;
      end else begin
        @(negedge clk);
      end
    end
    chk(done, "R10", "walk completed", {63'h0, done}, 64'h1);
  endtask

  // Builds a full chain; hugeMask bit L sets page-size bit at level L, stopAt limits entries
  task automatic buildChain(input logic [47:0] va, input logic [35:0] leaf,
                            input bit [3:0] hugeMask, input int entries);
    logic [35:0] fr [5];
    fr[0] = rootFrame; fr[1] = 36'h200; fr[2] = 36'h300; fr[3] = 36'h400; fr[4] = leaf;
    tN = 0;
    for (int l = 0; l < entries; l++) addPte(entryAddr(fr[l], va, l), mkPte(fr[l+1], hugeMask[l]));
  endtask

  task automatic testReset();
    chk(reqReady && !memReqValid && !respValid, "R1", "reset state",
        {61'h0, reqReady, memReqValid, respValid}, 64'h4);
  endtask

  task automatic testSmall(input logic [47:0] va, input int lat, input bit hold);
    logic [35:0] leaf = 36'hABCDE1234;
    logic [35:0] fr [4];
    fr[0] = rootFrame; fr[1] = 36'h200; fr[2] = 36'h300; fr[3] = 36'h400;
    buildChain(va, leaf, 4'b0000, 4);
    runWalk(va, lat, hold);
    chk(rdCount == 4, "R6", "read count", rdCount, 4);
    chk(rdAddr[0] == entryAddr(fr[0], va, 0), "R2", "root address", rdAddr[0],
        entryAddr(fr[0], va, 0));
    for (int l = 1; l < 4; l++)
      chk(rdAddr[l] == entryAddr(fr[l], va, l), "R3", "level address", rdAddr[l],
          entryAddr(fr[l], va, l));
    chk(gotPfn == leaf && !gotHuge && !gotFault, "R6", "small page result",
        {26'h0, gotHuge, gotFault, gotPfn}, {28'h0, leaf});
    if (hold) chk(rdCount == 4 && gotPfn == leaf, "R1", "busy request ignored", gotPfn, leaf);
  endtask

  task automatic testHuge();
    logic [47:0] va = 48'h7F3A_C5B1_9000 | 48'h0000_001F_E000;
    logic [35:0] hf = 36'h987654321;
    logic [35:0] exp;
    buildChain(va, 36'h0, 4'b0000, 2);
    addPte(entryAddr(36'h300, va, 2), mkPte(hf, 1'b1));
    exp = {hf[35:9], va[20:12]};
    runWalk(va, 1, 1'b0);
    chk(rdCount == 3, "R7", "huge read count", rdCount, 3);
    chk(gotHuge && !gotFault && gotPfn == exp, "R7", "huge result",
        {26'h0, gotHuge, gotFault, gotPfn}, {26'h0, 2'b10, exp});
  endtask

  task automatic testIgnoredSizeBit();
    logic [47:0] va = 48'h0123_4567_89AB;
    logic [35:0] leaf = 36'h0FEDC0BA9;
    buildChain(va, leaf, 4'b1011, 4);
    runWalk(va, 2, 1'b0);
    chk(rdCount == 4, "R8", "upper size bits ignored, read count", rdCount, 4);
    chk(gotPfn == leaf && !gotHuge && !gotFault, "R6", "last-level size bit ignored",
        {26'h0, gotHuge, gotFault, gotPfn}, {28'h0, leaf});
  endtask

  task automatic testFault(input int lvl);
    logic [47:0] va = 48'hFFFF_0000_F0F0 ^ (48'h1 << (20 + lvl));
    buildChain(va, 36'h1, 4'b0000, lvl);
    runWalk(va, 1, 1'b0);
    chk(rdCount == lvl + 1, "R9", "fault read count", rdCount, lvl + 1);
    chk(gotFault && !gotHuge && gotPfn == 36'h0 && gotLevel == 2'(lvl), "R9", "fault result",
        {24'h0, gotLevel, gotFault, gotHuge, gotPfn}, {24'h0, 2'(lvl), 2'b10, 36'h0});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSmall(48'hA5C3_1F2E_7D40, 1, 1'b0);
    testSmall(48'h3C96_0A5F_E123, 3, 1'b0);
    testSmall(48'h5555_AAAA_3000, 1, 1'b1);
    testHuge();
    testIgnoredSizeBit();
    testFault(0);
    testFault(2);
    testFault(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule